// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Deferred Store Buffer

This block is a direct-mapped, virtually tagged data cache for the memory stage of an in-order pipeline. Each of its lines holds one 32-bit word, a valid flag and a dirty flag. The tags and the data sit in separate arrays, and the line for the current request is read from both in the same cycle. The processor presents a request and holds it steady for as long as `stall` is high. A load that hits returns its word in the cycle it is presented.

A store that hits is not written into the data array straight away. The word and its address wait in a one-entry buffer, and they are written into the array when the next store is accepted. A load to the same word as the waiting store is served from the buffer, with the same timing as a normal hit.

On any miss, whether from a load or a store, the block raises `stall` and a refill controller takes over. If the victim line is dirty, the controller first writes it out to memory. It then reads the new word from memory, installs it, and lets the held request finish.

Top module: `dcache_deferred_store`

## Requirements
- R1: After reset every line is invalid and the store buffer is empty. With no request present, `stall`, `rd_valid` and `mem_req` are all low.
- R2: Address decoding works as follows. Bits [1:0] are ignored, the line index is bits [5:2] (16 lines), and the tag is bits [31:6]. A load whose line is valid and whose tag matches raises `rd_valid` in the same cycle with the line's word, and `stall` stays low.
- R3: A load or store whose line is invalid or has a different tag raises `stall` and keeps `rd_valid` low. The controller then issues a read (`mem_we`=0) at the word-aligned request address, and the access completes after the line is installed.
- R4: A store that hits is held in the one-entry buffer and does not change the data array or memory. A reset discards a buffered store that has not been committed.
- R5: A load whose word address equals the buffered store's word address returns the buffered data, with hit timing.
- R6: A store accepted while the buffer is full writes the older entry into the data array in the same cycle and marks that line dirty. The new entry is captured in the buffer.
- R7: A store to the same word as the buffered store replaces the buffered data, so a later load returns the newer value.
- R8: A miss whose victim line is invalid or clean issues no memory write.
- R9: A miss whose victim line is dirty first issues a write (`mem_we`=1) carrying the victim's address and word. The read for the new line follows only after that write has been acknowledged.
- R10: A store that misses refills the line, is then accepted into the buffer, and is visible to the next load.
- R11: A miss to the line index of the buffered store first merges the buffered word into the array. The victim is judged after the merge, so its writeback carries the buffered data.
- R12: `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack` is seen. `stall` stays high until the refill has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present (held while stalled) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store word |
| stall | output | 1 | Access cannot complete this cycle |
| rd_valid | output | 1 | Load completes this cycle with `rd_data` |
| rd_data | output | 32 | Load result |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Writeback word |
| mem_ack | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 32 | Memory read word, valid with `mem_ack` |

## Verification
Two functions can fall in the same cycle. The first is a store commit, where a store is accepted while the buffer is full, the older word goes into the array and the new one is captured. The second is a load forwarded from that buffer. The bench provokes this with back-to-back stores to neighbouring lines and to the same word. Each is followed by loads whose expected values come only from the requirements: the buffered value on forwarding, the array value once committed.

The sharper case is a miss to the index of the buffered store, where the merge and the eviction meet. The bench judges it at the memory port. The writeback address and data must carry the buffered word, and memory must later return that word on a refill.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = 4;
    localparam int OFF_W     = 2;
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;
    localparam int NUM_LINES = 1 << IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic  valid;
        logic  dirty;
        tag_t  tag;
        word_t data;
    } line_t;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_EVICT = 2'd1,
        FS_FETCH = 2'd2,
        FS_DONE  = 2'd3
    } fsm_e;

    function automatic idx_t idx_of(input addr_t a);
        return a[IDX_W+OFF_W-1:OFF_W];
    endfunction

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1:IDX_W+OFF_W];
    endfunction

    function automatic addr_t line_addr(input tag_t t, input idx_t i);
        return {t, i, {OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dcs_line_store.sv
module dcs_line_store
    import dcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    output line_t rd_line,
    input  logic  we,
    input  idx_t  wr_idx,
    input  line_t wr_line
);
    line_t lines [NUM_LINES];

    // Tag and data fields are read together for the addressed line.
    assign rd_line = lines[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) lines[i] <= '0;
        end else if (we) begin
            lines[wr_idx] <= wr_line;
        end
    end
endmodule

// File: rtl/dcs_store_buf.sv
module dcs_store_buf
    import dcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  capture,
    input  addr_t cap_addr,
    input  word_t cap_data,
    input  logic  clear,
    output logic  valid,
    output addr_t addr,
    output word_t data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else if (capture) begin
            valid <= 1'b1;
            addr  <= cap_addr;
            data  <= cap_data;
        end else if (clear) begin
            valid <= 1'b0;
        end
    end

    // R4: an accepted store always leaves an occupied entry behind
    p_capture_fills_r4: assert property (@(posedge clk) disable iff (rst)
        capture |=> valid);
endmodule

// File: rtl/dcs_refill_fsm.sv
module dcs_refill_fsm
    import dcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  victim_dirty,
    input  addr_t victim_addr,
    input  word_t victim_data,
    input  addr_t fill_addr,
    output logic  idle,
    output logic  mem_req,
    output logic  mem_we,
    output addr_t mem_addr,
    output word_t mem_wdata,
    input  logic  mem_ack,
    input  word_t mem_rdata,
    output logic  fill_we,
    output word_t fill_data
);
    fsm_e  state, state_nx;
    addr_t v_addr;
    word_t v_data;

    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE:  if (start) state_nx = victim_dirty ? FS_EVICT : FS_FETCH;
            FS_EVICT: if (mem_ack) state_nx = FS_FETCH;
            FS_FETCH: if (mem_ack) state_nx = FS_DONE;
            FS_DONE:  state_nx = FS_IDLE;
            default:  state_nx = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FS_IDLE;
            v_addr <= '0;
            v_data <= '0;
        end else begin
            state <= state_nx;
            if (state == FS_IDLE && start) begin
                v_addr <= victim_addr;
                v_data <= victim_data;
            end
        end
    end

    assign idle      = (state == FS_IDLE);
    assign mem_req   = (state == FS_EVICT) || (state == FS_FETCH);
    assign mem_we    = (state == FS_EVICT);
    assign mem_addr  = (state == FS_EVICT) ? v_addr : fill_addr;
    assign mem_wdata = v_data;
    assign fill_we   = (state == FS_FETCH) && mem_ack;
    assign fill_data = mem_rdata;

    // R12: an unanswered request stays up with the same address and direction
    p_req_held_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: the refill read follows an acknowledged writeback
    p_evict_then_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        (state == FS_EVICT && mem_ack) |=> (state == FS_FETCH && !mem_we));

    // R3: an acknowledged read finishes the refill in the next cycle
    p_fetch_then_done_r3: assert property (@(posedge clk) disable iff (rst)
        (state == FS_FETCH && mem_ack) |=> (state == FS_DONE && !mem_req));
endmodule

// File: rtl/dcache_deferred_store.sv
module dcache_deferred_store
    import dcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              stall,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    idx_t  cur_idx;
    tag_t  cur_tag;
    line_t cur_line;
    logic  tag_hit, fsm_idle;
    logic  sb_valid;
    addr_t sb_addr;
    word_t sb_data;
    idx_t  sb_idx;
    logic  sb_match, conflict;
    logic  accept, miss_now, drain, commit, start;
    logic  fill_we;
    word_t fill_data;
    logic  arr_we;
    idx_t  arr_idx;
    line_t arr_line;

    assign cur_idx  = idx_of(req_addr);
    assign cur_tag  = tag_of(req_addr);
    assign tag_hit  = cur_line.valid && (cur_line.tag == cur_tag);
    assign sb_idx   = idx_of(sb_addr);
    assign sb_match = sb_valid && (sb_addr[ADDR_W-1:OFF_W] == req_addr[ADDR_W-1:OFF_W]);
    assign conflict = sb_valid && (sb_idx == cur_idx);

    assign accept   = req_valid && fsm_idle && tag_hit;
    assign miss_now = req_valid && fsm_idle && !tag_hit;
    assign drain    = miss_now && conflict;      // merge buffered word before eviction
    assign start    = miss_now && !conflict;
    assign commit   = accept && req_write && sb_valid;

    assign stall    = !fsm_idle || (req_valid && !tag_hit);
    assign rd_valid = accept && !req_write;
    assign rd_data  = sb_match ? sb_data : cur_line.data;

    // One write port: refills own it while the controller is busy,
    // buffer commits and merges only happen while it is idle.
    assign arr_we  = fill_we || commit || drain;
    assign arr_idx = fill_we ? cur_idx : sb_idx;
    always_comb begin
        if (fill_we)
            arr_line = '{valid: 1'b1, dirty: 1'b0, tag: cur_tag, data: fill_data};
        else
            arr_line = '{valid: 1'b1, dirty: 1'b1, tag: tag_of(sb_addr), data: sb_data};
    end

    dcs_line_store u_lines (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (cur_idx),
        .rd_line (cur_line),
        .we      (arr_we),
        .wr_idx  (arr_idx),
        .wr_line (arr_line)
    );

    dcs_store_buf u_sbuf (
        .clk      (clk),
        .rst      (rst),
        .capture  (accept && req_write),
        .cap_addr (req_addr),
        .cap_data (req_wdata),
        .clear    (drain),
        .valid    (sb_valid),
        .addr     (sb_addr),
        .data     (sb_data)
    );

    dcs_refill_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .victim_dirty (cur_line.valid && cur_line.dirty),
        .victim_addr  (line_addr(cur_line.tag, cur_idx)),
        .victim_data  (cur_line.data),
        .fill_addr    ({req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}),
        .idle         (fsm_idle),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .fill_we      (fill_we),
        .fill_data    (fill_data)
    );

    // R11: a buffered store's line stays resident until the store is merged
    p_buffered_line_resident_r11: assert property (@(posedge clk) disable iff (rst)
        (sb_valid && sb_idx == cur_idx) |-> (cur_line.valid && cur_line.tag == tag_of(sb_addr)));

    // R3: nothing completes while a refill is in flight
    p_no_load_during_refill_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (!rd_valid && stall));
endmodule

// File: tb/dcache_deferred_store_tb.sv
`timescale 1ns/1ps
module dcache_deferred_store_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic        stall, rd_valid;
    logic [31:0] rd_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    always #4 clk = ~clk;   // 125 MHz

    dcache_deferred_store u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .stall(stall), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [256];
    int          ack_delay = 0;
    int          wcnt = 0;
    int          wb_count = 0;
    logic [31:0] last_wb_addr, last_wb_data;
    int          hold_err = 0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr;
    logic        prev_we;

    initial for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt >= ack_delay) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (!rst && mem_req && mem_we && mem_ack) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wb_count     <= wb_count + 1;
            last_wb_addr <= mem_addr;
            last_wb_data <= mem_wdata;
        end
    end

    // R12 monitor: a pending request must reappear unchanged
    always @(negedge clk) begin
        if (!rst && prev_pend && !(mem_req && mem_addr == prev_addr && mem_we == prev_we))
            hold_err++;
        prev_pend = !rst && mem_req && !mem_ack;
        prev_addr = mem_addr;
        prev_we   = mem_we;
    end

    // ---------------- checking ----------------
    int applied = 0;
    int failed  = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] q, output logic rv,
                          output logic missed, output int wbs);
        int wb0;
        wb0 = wb_count;
        missed = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
        #1;
        while (stall) begin
            missed = 1'b1;
            @(negedge clk);
            #1;
        end
        q  = rd_data;
        rv = rd_valid;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        wbs = wb_count - wb0;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        miss;
        logic        wb;
        logic [31:0] wb_addr;
        logic [31:0] wb_data;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h000, 32'h0,         32'hA000_0000, 1'b1, 1'b0, 32'h0,   32'h0},          // R1 R3 cold miss
        '{1'b0, 32'h000, 32'h0,         32'hA000_0000, 1'b0, 1'b0, 32'h0,   32'h0},          // R2 hit
        '{1'b0, 32'h004, 32'h0,         32'hA000_0001, 1'b1, 1'b0, 32'h0,   32'h0},          // R3
        '{1'b1, 32'h000, 32'h1111_1111, 32'h0,         1'b0, 1'b0, 32'h0,   32'h0},          // R4 buffered
        '{1'b0, 32'h000, 32'h0,         32'h1111_1111, 1'b0, 1'b0, 32'h0,   32'h0},          // R5 forward
        '{1'b1, 32'h004, 32'h2222_2222, 32'h0,         1'b0, 1'b0, 32'h0,   32'h0},          // R6 commit old
        '{1'b0, 32'h000, 32'h0,         32'h1111_1111, 1'b0, 1'b0, 32'h0,   32'h0},          // R6 from array
        '{1'b1, 32'h004, 32'h3333_3333, 32'h0,         1'b0, 1'b0, 32'h0,   32'h0},          // R7 same word
        '{1'b0, 32'h004, 32'h0,         32'h3333_3333, 1'b0, 1'b0, 32'h0,   32'h0},          // R7 newer value
        '{1'b0, 32'h040, 32'h0,         32'hA000_0010, 1'b1, 1'b1, 32'h000, 32'h1111_1111},  // R9 dirty victim
        '{1'b0, 32'h000, 32'h0,         32'h1111_1111, 1'b1, 1'b0, 32'h0,   32'h0},          // R8 clean victim
        '{1'b0, 32'h044, 32'h0,         32'hA000_0011, 1'b1, 1'b1, 32'h004, 32'h3333_3333},  // R11 merge first
        '{1'b0, 32'h004, 32'h0,         32'h3333_3333, 1'b1, 1'b0, 32'h0,   32'h0},          // R11 memory holds it
        '{1'b1, 32'h080, 32'h4444_4444, 32'h0,         1'b1, 1'b0, 32'h0,   32'h0},          // R10 store miss
        '{1'b0, 32'h080, 32'h0,         32'h4444_4444, 1'b0, 1'b0, 32'h0,   32'h0}           // R10 visible
    };

    initial begin
        logic [31:0] q;
        logic rv, missed;
        int wbs;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk); #1;
        check("R1 stall after reset", {31'b0, stall}, 32'd0);
        check("R1 rd_valid after reset", {31'b0, rd_valid}, 32'd0);
        check("R1 mem_req after reset", {31'b0, mem_req}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            access(VECS[v].we, VECS[v].addr, VECS[v].wdata, q, rv, missed, wbs);
            check($sformatf("R3 miss flag vec %0d", v), {31'b0, missed}, {31'b0, VECS[v].miss});
            check($sformatf("R9 writeback count vec %0d", v), wbs, {31'b0, VECS[v].wb});
            check($sformatf("R2 rd_valid vec %0d", v), {31'b0, rv}, {31'b0, !VECS[v].we});
            if (!VECS[v].we)
                check($sformatf("R2 R5 load data vec %0d", v), q, VECS[v].exp);
            if (VECS[v].wb) begin
                check($sformatf("R9 writeback addr vec %0d", v), last_wb_addr, VECS[v].wb_addr);
                check($sformatf("R11 writeback data vec %0d", v), last_wb_data, VECS[v].wb_data);
            end
        end

        // R12 with a slow memory; miss on the buffered store's index (R11)
        ack_delay = 3;
        access(1'b0, 32'h0C0, 32'h0, q, rv, missed, wbs);
        check("R12 slow load data", q, 32'hA000_0030);
        check("R11 slow merge writeback count", wbs, 32'd1);
        check("R11 slow writeback addr", last_wb_addr, 32'h080);
        check("R11 slow writeback data", last_wb_data, 32'h4444_4444);
        check("R12 request held until ack", hold_err, 32'd0);
        ack_delay = 0;

        // R4: reset throws away an uncommitted store
        access(1'b1, 32'h100, 32'h5555_5555, q, rv, missed, wbs);
        check("R10 store miss refills", {31'b0, missed}, 32'd1);
        check("R8 clean victim no write", wbs, 32'd0);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        access(1'b0, 32'h100, 32'h0, q, rv, missed, wbs);
        check("R1 line invalid after reset", {31'b0, missed}, 32'd1);
        check("R4 discarded store not seen", q, 32'hA000_0040);
        check("R8 no write after reset", wbs, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failed++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end
endmodule